// File: doc/BRIEF.md
# Page Access-Rights and Fault Checker

This block takes the result of a translation lookup and decides what a memory access may do. From the entry's rights type, its two privilege bounds and its status flags, it works out a permitted read/write/execute mask. It also produces the physical address and a single fault code for the attempted access. Lookup storage and the delivery of the fault to the pipeline stay with the caller.

When translation is switched off, the block converts the absolute address into a physical one itself and grants every permission. In wide mode the low physical-width bits are sign-extended. In narrow mode the low 32 bits are placed in the memory, I/O or firmware region, chosen from their top two nibbles. The block is purely combinational, so its outputs follow its inputs within the same cycle.

Top module: `ptc_checker`

## Requirements
- R1: Privilege numbers run 0 (most privileged) to 3. Read needs priv <= pl1, write needs priv <= pl2, and execute needs pl2 <= priv <= pl1. The mask output has bit 0 = read, bit 1 = write and bit 2 = execute.
- R2: Rights type 0 gives read only, 1 gives read and write, 2 gives read and execute, and 3 gives all three. Each right is further limited by R1. Types 4 to 7 give execute only.
- R3: With the id check enabled and a nonzero access id, a protection-id register equal to (id*2+1) clears the write bit. A write access then raises fault 5 and ends the checks. An id of zero, or a disabled check, leaves the rights unchanged.
- R4: On a lookup miss the mask is 0 and the physical address is 0. The fault is 1 for an execute access and 2 for any other kind, none included.
- R5: Access kind encoding: 0 none, 1 read, 2 write, 3 execute. Kind none on a hit raises no fault and skips the rights and flag checks.
- R6: On a hit, an access whose kind bit is absent from the mask raises fault 3 for execute and fault 4 otherwise, and the flag checks are skipped.
- R7: After the rights check the flags are applied in order, each later fault replacing an earlier one. Dirty flag clear: a write gets fault 6 and write is cleared. Break flag set: a write gets fault 7 and write is cleared. Reference flag set: a non-execute access gets fault 8 and only execute is kept.
- R8: On a hit with translation on, the physical address is the entry's physical base plus the offset of the address from the entry's virtual base.
- R9: With translation off and wide mode set, the physical address is address bits 39:0 sign-extended to 64 bits.
- R10: With translation off in narrow mode, bits 31:0 are used. If their top nibble is not F they are zero-extended. If it is F and bits 27:24 are nonzero they are sign-extended. If it is F and bits 27:24 are zero they are zero-extended and bits 63:36 are set.
- R11: With translation off the mask is 7 and the fault is 0, whatever the lookup inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xlate_off_i | input | 1 | Translation disabled; use absolute mapping |
| wide_i | input | 1 | Wide addressing mode for absolute mapping |
| vaddr_i | input | 64 | Address of the access |
| hit_i | input | 1 | Lookup found a matching entry |
| ent_va_base_i | input | 64 | Virtual base of the matching entry |
| ent_pa_i | input | 64 | Physical base of the matching entry |
| ar_type_i | input | 3 | Entry rights type |
| pl1_i | input | 2 | Entry read/execute privilege bound |
| pl2_i | input | 2 | Entry write/execute privilege bound |
| acc_id_i | input | 31 | Entry access id (0 = public) |
| t_i | input | 1 | Reference-trap flag |
| d_i | input | 1 | Dirty flag |
| b_i | input | 1 | Break flag |
| priv_i | input | 2 | Current privilege level |
| pid_chk_en_i | input | 1 | Enable protection-id matching |
| pid_regs_i | input | 128 | Four 32-bit protection-id registers, register 0 in the low bits |
| acc_kind_i | input | 2 | Access kind |
| perm_o | output | 3 | Permitted mask {X,W,R} |
| phys_o | output | 64 | Physical address |
| fault_o | output | 4 | Fault code, 0 = none |

## Verification
The hardest case to reach from the ports is a fault that is replaced later in the chain. A write that passes the rights check with the dirty flag clear and the break and reference flags set must report the reference fault. At the same time the mask must keep only execute. The stimulus reaches every such overlap by sweeping all combinations of privilege, both bounds, rights type, access kind and the three flags. Each result is compared with a model built from the requirement text. Protection-id matches, misses and the three absolute-address regions are then driven with chosen vectors that sit on the boundaries between cases.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_kind_e;

  typedef enum logic [3:0] {
    FLT_NONE      = 4'd0,
    FLT_ITLB_MISS = 4'd1,
    FLT_DTLB_MISS = 4'd2,
    FLT_IPROT     = 4'd3,
    FLT_DRIGHTS   = 4'd4,
    FLT_PID       = 4'd5,
    FLT_DIRTY     = 4'd6,
    FLT_BREAK     = 4'd7,
    FLT_REF       = 4'd8
  } fault_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

endpackage

// File: rtl/ptc_rights.sv
module ptc_rights #(
  parameter int PL_W = 2
) (
  input  logic [PL_W-1:0] priv_i,
  input  logic [PL_W-1:0] pl1_i,
  input  logic [PL_W-1:0] pl2_i,
  input  logic [2:0]      ar_type_i,
  output logic [2:0]      base_mask_o
);
  import ptc_pkg::*;

  logic may_rd, may_wr, may_ex;

  // privilege window: lower number means more privilege
  assign may_rd = (priv_i <= pl1_i);
  assign may_wr = (priv_i <= pl2_i);
  assign may_ex = (pl2_i <= priv_i) && (priv_i <= pl1_i);

  always_comb begin
    base_mask_o = '0;
    case (ar_type_i)
      3'd0: base_mask_o[PERM_R] = may_rd;
      3'd1: begin
        base_mask_o[PERM_R] = may_rd;
        base_mask_o[PERM_W] = may_wr;
      end
      3'd2: begin
        base_mask_o[PERM_R] = may_rd;
        base_mask_o[PERM_X] = may_ex;
      end
      3'd3: begin
        base_mask_o[PERM_R] = may_rd;
        base_mask_o[PERM_W] = may_wr;
        base_mask_o[PERM_X] = may_ex;
      end
      default: base_mask_o[PERM_X] = may_ex;
    endcase
  end

endmodule

// File: rtl/ptc_pid_match.sv
module ptc_pid_match #(
  parameter int AID_W   = 31,
  parameter int NUM_PID = 4
) (
  input  logic [AID_W-1:0]             acc_id_i,
  input  logic                         chk_en_i,
  input  logic [NUM_PID*(AID_W+1)-1:0] pid_regs_i,
  output logic                         wr_lock_o
);
  localparam int PID_W = AID_W + 1;

  logic [PID_W-1:0]   want;
  logic [NUM_PID-1:0] eq_vec;

  // a match needs the id in the upper bits and the low bit set
  assign want = {acc_id_i, 1'b1};

  for (genvar g = 0; g < NUM_PID; g++) begin : g_cmp
    assign eq_vec[g] = (pid_regs_i[g*PID_W +: PID_W] == want);
  end

  assign wr_lock_o = chk_en_i && (|acc_id_i) && (|eq_vec);

endmodule

// File: rtl/ptc_fault_chain.sv
module ptc_fault_chain
  import ptc_pkg::*;
(
  input  logic      hit_i,
  input  acc_kind_e kind_i,
  input  logic [2:0] base_mask_i,
  input  logic      wr_lock_i,
  input  logic      t_i,
  input  logic      d_i,
  input  logic      b_i,
  output logic [2:0] mask_o,
  output fault_e    fault_o
);

  logic need_ok;

  always_comb begin
    case (kind_i)
      ACC_READ:  need_ok = base_mask_i[PERM_R];
      ACC_WRITE: need_ok = base_mask_i[PERM_W] && !wr_lock_i;
      ACC_EXEC:  need_ok = base_mask_i[PERM_X];
      default:   need_ok = 1'b1;
    endcase
  end

  always_comb begin
    mask_o  = base_mask_i;
    fault_o = FLT_NONE;
    if (!hit_i) begin
      mask_o  = '0;
      fault_o = (kind_i == ACC_EXEC) ? FLT_ITLB_MISS : FLT_DTLB_MISS;
    end else begin
      if (wr_lock_i) mask_o[PERM_W] = 1'b0;
      if (wr_lock_i && kind_i == ACC_WRITE) begin
        fault_o = FLT_PID;
      end else if (kind_i == ACC_NONE) begin
        fault_o = FLT_NONE;
      end else if (!need_ok) begin
        fault_o = (kind_i == ACC_EXEC) ? FLT_IPROT : FLT_DRIGHTS;
      end else begin
        if (!d_i) begin
          if (kind_i == ACC_WRITE) fault_o = FLT_DIRTY;
          mask_o[PERM_W] = 1'b0;
        end
        if (b_i) begin
          if (kind_i == ACC_WRITE) fault_o = FLT_BREAK;
          mask_o[PERM_W] = 1'b0;
        end
        if (t_i) begin
          if (kind_i != ACC_EXEC) fault_o = FLT_REF;
          mask_o = mask_o & 3'b100;
        end
      end
    end
  end

  always_comb begin
    if (fault_o == FLT_PID)
      AST_PID_NO_WRITE: assert (!mask_o[PERM_W] && wr_lock_i) else $error("pid fault with write kept"); // R3
    if (hit_i && kind_i == ACC_NONE)
      AST_NONE_NO_FAULT: assert (fault_o == FLT_NONE) else $error("fault on kind none"); // R5
    if (fault_o == FLT_DIRTY || fault_o == FLT_BREAK)
      AST_WRITE_STRIPPED: assert (!mask_o[PERM_W] && kind_i == ACC_WRITE) else $error("flag fault keeps write"); // R7
    if (fault_o == FLT_REF)
      AST_REF_EXEC_ONLY: assert (mask_o[1:0] == 2'b00) else $error("reference fault keeps data rights"); // R7
    if (fault_o == FLT_IPROT)
      AST_IPROT_KIND: assert (kind_i == ACC_EXEC && hit_i) else $error("instruction protection on data"); // R6
  end

endmodule

// File: rtl/ptc_abs_map.sv
module ptc_abs_map #(
  parameter int VA_W = 64,
  parameter int PA_W = 40
) (
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            wide_i,
  output logic [VA_W-1:0] phys_o
);
  localparam int              EXT_W   = VA_W - PA_W;
  localparam int              HI32_W  = VA_W - 32;
  localparam logic [VA_W-1:0] FW_MASK = {VA_W{1'b1}} << (PA_W - 4);

  logic [31:0] lo;
  logic        unused_hi;

  assign lo        = vaddr_i[31:0];
  assign unused_hi = ^vaddr_i[VA_W-1:PA_W];

  always_comb begin
    if (wide_i) begin
      phys_o = {{EXT_W{vaddr_i[PA_W-1]}}, vaddr_i[PA_W-1:0]};
    end else if (lo[31:28] != 4'hF) begin
      phys_o = {{HI32_W{1'b0}}, lo};
    end else if (lo[27:24] != 4'h0) begin
      phys_o = {{HI32_W{1'b1}}, lo};
    end else begin
      phys_o = {{HI32_W{1'b0}}, lo} | FW_MASK;
    end
  end

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int VA_W    = 64,
  parameter int PA_W    = 40,
  parameter int AID_W   = 31,
  parameter int PL_W    = 2,
  parameter int NUM_PID = 4
) (
  input  logic                         xlate_off_i,
  input  logic                         wide_i,
  input  logic [VA_W-1:0]              vaddr_i,
  input  logic                         hit_i,
  input  logic [VA_W-1:0]              ent_va_base_i,
  input  logic [VA_W-1:0]              ent_pa_i,
  input  logic [2:0]                   ar_type_i,
  input  logic [PL_W-1:0]              pl1_i,
  input  logic [PL_W-1:0]              pl2_i,
  input  logic [AID_W-1:0]             acc_id_i,
  input  logic                         t_i,
  input  logic                         d_i,
  input  logic                         b_i,
  input  logic [PL_W-1:0]              priv_i,
  input  logic                         pid_chk_en_i,
  input  logic [NUM_PID*(AID_W+1)-1:0] pid_regs_i,
  input  logic [1:0]                   acc_kind_i,
  output logic [2:0]                   perm_o,
  output logic [VA_W-1:0]              phys_o,
  output logic [3:0]                   fault_o
);
  import ptc_pkg::*;

  acc_kind_e       kind;
  logic [2:0]      base_mask;
  logic            wr_lock;
  logic [2:0]      chain_mask;
  fault_e          chain_fault;
  logic [VA_W-1:0] abs_phys;
  logic [VA_W-1:0] xl_phys;

  assign kind = acc_kind_e'(acc_kind_i);

  ptc_rights #(.PL_W(PL_W)) u_rights (
    .priv_i     (priv_i),
    .pl1_i      (pl1_i),
    .pl2_i      (pl2_i),
    .ar_type_i  (ar_type_i),
    .base_mask_o(base_mask)
  );

  ptc_pid_match #(.AID_W(AID_W), .NUM_PID(NUM_PID)) u_pid (
    .acc_id_i  (acc_id_i),
    .chk_en_i  (pid_chk_en_i),
    .pid_regs_i(pid_regs_i),
    .wr_lock_o (wr_lock)
  );

  ptc_fault_chain u_chain (
    .hit_i      (hit_i),
    .kind_i     (kind),
    .base_mask_i(base_mask),
    .wr_lock_i  (wr_lock),
    .t_i        (t_i),
    .d_i        (d_i),
    .b_i        (b_i),
    .mask_o     (chain_mask),
    .fault_o    (chain_fault)
  );

  ptc_abs_map #(.VA_W(VA_W), .PA_W(PA_W)) u_abs (
    .vaddr_i(vaddr_i),
    .wide_i (wide_i),
    .phys_o (abs_phys)
  );

  assign xl_phys = hit_i ? (ent_pa_i + (vaddr_i - ent_va_base_i)) : '0;

  always_comb begin
    if (xlate_off_i) begin
      perm_o  = 3'b111;
      phys_o  = abs_phys;
      fault_o = FLT_NONE;
    end else begin
      perm_o  = chain_mask;
      phys_o  = xl_phys;
      fault_o = chain_fault;
    end
  end

  always_comb begin
    if (!xlate_off_i && !hit_i)
      AST_MISS_NO_RIGHTS: assert (perm_o == 3'b000 && phys_o == '0) else $error("miss with rights"); // R4
    if (xlate_off_i)
      AST_OFF_FULL: assert (perm_o == 3'b111 && fault_o == 4'd0) else $error("absolute access restricted"); // R11
  end

endmodule

// File: tb/sim_ptc_checker.sv
module sim_ptc_checker;

  logic clk;
  logic rst_n;
  int   checks;
  int   errors;
  bit   finished;
  int   cyc;

  logic         xlate_off, wide, hit, t, d, b, pid_en;
  logic [63:0]  vaddr, va_base, pa_base, phys;
  logic [2:0]   ar_type, perm;
  logic [1:0]   pl1, pl2, priv, kind;
  logic [30:0]  aid;
  logic [127:0] pids;
  logic [3:0]   fault;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  ptc_checker u0 (
    .xlate_off_i  (xlate_off),
    .wide_i       (wide),
    .vaddr_i      (vaddr),
    .hit_i        (hit),
    .ent_va_base_i(va_base),
    .ent_pa_i     (pa_base),
    .ar_type_i    (ar_type),
    .pl1_i        (pl1),
    .pl2_i        (pl2),
    .acc_id_i     (aid),
    .t_i          (t),
    .d_i          (d),
    .b_i          (b),
    .priv_i       (priv),
    .pid_chk_en_i (pid_en),
    .pid_regs_i   (pids),
    .acc_kind_i   (kind),
    .perm_o       (perm),
    .phys_o       (phys),
    .fault_o      (fault)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // expected mask and fault from the requirement text
  function automatic void model(input int pv, input int p1, input int p2, input int ty,
                                input int k, input bit tt, input bit dd, input bit bb,
                                input bit lock, output logic [2:0] m, output logic [3:0] f);
    bit r, w, x;
    r = (pv <= p1);
    w = (pv <= p2);
    x = (p2 <= pv) && (pv <= p1);
    case (ty)
      0: m = {1'b0, 1'b0, r};
      1: m = {1'b0, w, r};
      2: m = {x, 1'b0, r};
      3: m = {x, w, r};
      default: m = {x, 1'b0, 1'b0};
    endcase
    f = 4'd0;
    if (lock) m[1] = 1'b0;
    if (lock && k == 2) begin f = 4'd5; return; end
    if (k == 0) return;
    if (!m[k-1]) begin f = (k == 3) ? 4'd3 : 4'd4; return; end
    if (!dd) begin if (k == 2) f = 4'd6; m[1] = 1'b0; end
    if (bb)  begin if (k == 2) f = 4'd7; m[1] = 1'b0; end
    if (tt)  begin if (k != 3) f = 4'd8; m = m & 3'b100; end
  endfunction

  task automatic chk_mf(input string tag, input logic [2:0] em, input logic [3:0] ef);
    checks = checks + 1;
    if (perm !== em || fault !== ef) begin
      errors = errors + 1;
      $display("FAIL %s: actual perm=%b fault=%0d expected perm=%b fault=%0d", tag, perm, fault, em, ef);
    end
  endtask

  task automatic chk_pa(input string tag, input logic [63:0] ep);
    checks = checks + 1;
    if (phys !== ep) begin
      errors = errors + 1;
      $display("FAIL %s: actual phys=%h expected phys=%h", tag, phys, ep);
    end
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic set_entry(input int ty, input int p1, input int p2, input int pv, input int k);
    @(posedge clk);
    ar_type = 3'(ty); pl1 = 2'(p1); pl2 = 2'(p2); priv = 2'(pv); kind = 2'(k);
  endtask

  initial begin
    logic [2:0] em;
    logic [3:0] ef;
    checks = 0; errors = 0; finished = 0; cyc = 0;
    rst_n = 1'b0;
    xlate_off = 0; wide = 0; hit = 1; t = 0; d = 1; b = 0; pid_en = 0;
    vaddr = '0; va_base = '0; pa_base = '0; ar_type = 0; pl1 = 0; pl2 = 0;
    priv = 0; kind = 0; aid = '0; pids = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();
    // initial quiet state: hit, type 0, priv 0, kind none
    chk_mf("R5 idle state", 3'b001, 4'd0);

    // exhaustive sweep: R1 R2 R5 R6 R7
    for (int pv = 0; pv < 4; pv++)
      for (int p1 = 0; p1 < 4; p1++)
        for (int p2 = 0; p2 < 4; p2++)
          for (int ty = 0; ty < 8; ty++)
            for (int k = 0; k < 4; k++)
              for (int fl = 0; fl < 8; fl++) begin
                set_entry(ty, p1, p2, pv, k);
                t = fl[2]; d = fl[1]; b = fl[0];
                model(pv, p1, p2, ty, k, fl[2], fl[1], fl[0], 1'b0, em, ef);
                settle();
                chk_mf("R1 R2 R5 R6 R7 sweep", em, ef);
              end

    // R7 override: write, dirty clear, break and ref set -> ref fault, exec only
    set_entry(3, 0, 0, 0, 2); t = 1; d = 0; b = 1;
    settle();
    chk_mf("R7 reference overrides break", 3'b100, 4'd8);

    // R3 protection id: id 5 -> register value 11
    t = 0; d = 1; b = 0;
    aid = 31'd5; pid_en = 1; pids = '0; pids[2*32 +: 32] = 32'd11;
    set_entry(1, 3, 3, 0, 2);
    settle();
    chk_mf("R3 write under id match", 3'b001, 4'd5);
    set_entry(1, 3, 3, 0, 1);
    settle();
    chk_mf("R3 read under id match", 3'b001, 4'd0);
    pids[2*32 +: 32] = 32'd10;
    set_entry(1, 3, 3, 0, 2);
    settle();
    chk_mf("R3 low bit clear no match", 3'b011, 4'd0);
    pids[0 +: 32] = 32'd11; pid_en = 0;
    set_entry(1, 3, 3, 0, 2);
    settle();
    chk_mf("R3 check disabled", 3'b011, 4'd0);
    pid_en = 1; aid = '0; pids[3*32 +: 32] = 32'd1;
    set_entry(1, 3, 3, 0, 2);
    settle();
    chk_mf("R3 public page", 3'b011, 4'd0);

    // R4 misses
    aid = '0; hit = 0; vaddr = 64'h1234_5000; pa_base = 64'h99_0000;
    set_entry(3, 3, 0, 0, 3);
    settle();
    chk_mf("R4 exec miss", 3'b000, 4'd1);
    chk_pa("R4 miss phys", 64'd0);
    set_entry(3, 3, 0, 0, 1);
    settle();
    chk_mf("R4 read miss", 3'b000, 4'd2);
    set_entry(3, 3, 0, 0, 0);
    settle();
    chk_mf("R4 none miss", 3'b000, 4'd2);

    // R8 translated address
    hit = 1;
    @(posedge clk);
    va_base = 64'h0000_7fff_0abc_0000; pa_base = 64'h0000_0012_3450_0000;
    vaddr = 64'h0000_7fff_0abc_1234;
    settle();
    chk_pa("R8 translated", 64'h0000_0012_3450_1234);

    // R9 wide absolute
    @(posedge clk);
    xlate_off = 1; wide = 1; hit = 0; kind = 2'd2;
    vaddr = 64'h0000_0080_0000_1000;
    settle();
    chk_pa("R9 sign bit set", 64'hffff_ff80_0000_1000);
    chk_mf("R11 wide full rights", 3'b111, 4'd0);
    @(posedge clk);
    vaddr = 64'habcd_0001_0000_0000;
    settle();
    chk_pa("R9 upper bits dropped", 64'h0000_0001_0000_0000);

    // R10 narrow absolute
    @(posedge clk);
    wide = 0; vaddr = 64'hdead_beef_1234_5678;
    settle();
    chk_pa("R10 memory region", 64'h0000_0000_1234_5678);
    @(posedge clk);
    vaddr = 64'h0000_0000_f100_0000;
    settle();
    chk_pa("R10 io region", 64'hffff_ffff_f100_0000);
    @(posedge clk);
    vaddr = 64'h0000_0000_f000_1234;
    settle();
    chk_pa("R10 firmware region", 64'hffff_fff0_f000_1234);
    @(posedge clk);
    vaddr = 64'h0000_0000_efff_ffff;
    settle();
    chk_pa("R10 just below F nibble", 64'h0000_0000_efff_ffff);
    hit = 1; t = 1; d = 0; b = 1; ar_type = 0; priv = 3; pl1 = 0;
    settle();
    chk_mf("R11 lookup inputs ignored", 3'b111, 4'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule